// File: doc/BRIEF.md
# Auto-incrementing register write port

This block sits between a command-processing microcontroller and the register fabric of a graphics engine. The controller programs registers through a single command port. Each command names a destination and carries a 32-bit value. Two of the destinations latch a target address. One of them trusts the address. The other marks it for checking against a small programmable table of protected offset ranges. A third destination emits one register write of the value to the latched address on a valid/ready output bus, and then moves the address on by one. A separate pair of destinations forms an independent direct write path with its own address register.

The latched address is 32 bits wide. Its low 18 bits are the register offset. Bit 18 freezes the offset so that a stream of data words lands on one register. Offset bit 11 picks the bank of a double-buffered register. A non-zero top byte moves the write into a separate pipe-register space. Certain pipe codes carry no data: writing an address with one of those codes raises a one-cycle trigger strobe and emits no bus write.

A write that the checked destination sends into a protected range is dropped and sets a sticky error flag. The writer stalls while the output bus holds a word that the consumer has not taken.

Top module: `regwr_port`

## Requirements
- R1: After reset, wr_valid, trig_valid and prot_err are 0 and cmd_ready is 1. All protection ranges start disabled.
- R2: A command is accepted when cmd_valid and cmd_ready are both high at a clock edge. Destination codes are 0 (unchecked address), 1 (checked address), 2 (data), 3 (direct address) and 4 (direct data). An accepted data command presents exactly one write on the bus from the next cycle, carrying the current offset (address bits 17:0) and the value. After it, the offset advances by one.
- R3: While bit 18 of the latched address is 1, data commands leave the offset unchanged, so every write goes to the same offset.
- R4: A write whose latched address has non-zero bits 31:24 has wr_pipe=1 and wr_code equal to those bits. Otherwise wr_pipe=0 and wr_code=0.
- R5: An accepted address command (code 0 or 1) whose value bits 31:24 equal 0x84 or 0x85 pulses trig_valid for one cycle in the next cycle, with trig_code equal to those bits. No bus write results.
- R6: After an unchecked address command, data writes reach the bus even when their offset lies in an enabled protected range.
- R7: After a checked address command, a normal-space data write whose offset lies inside an enabled inclusive range [lo, hi] is not emitted. It sets prot_err from the next cycle, and the offset still advances. prot_err stays 1 until a cycle with err_clr high.
- R8: wr_bank equals bit 11 of the emitted offset.
- R9: The direct path keeps its own 18-bit offset. Each direct data write emits (offset, value) in normal space, then increments that offset. This leaves the main address untouched, and the main path leaves the direct offset untouched.
- R10: While wr_valid is 1 and wr_ready is 0, cmd_ready is 0, and wr_valid, wr_off and wr_data hold their values.
- R11: Offset increments wrap within 18 bits, from 0x3FFFF to 0x00000, and leave address bits 31:18 unchanged.
- R12: Commands with destination codes 5 to 7 change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_dest | input | 3 | Destination code |
| cmd_value | input | 32 | Address or data value |
| prot_we | input | 1 | Write one protection range entry |
| prot_idx | input | 2 | Entry index |
| prot_lo | input | 18 | Lowest protected offset |
| prot_hi | input | 18 | Highest protected offset |
| prot_en | input | 1 | Entry enable |
| err_clr | input | 1 | Clear the violation flag |
| prot_err | output | 1 | Sticky violation flag |
| wr_valid | output | 1 | Register write present |
| wr_ready | input | 1 | Consumer takes the write |
| wr_pipe | output | 1 | Write targets pipe-register space |
| wr_code | output | 8 | Pipe code (0 in normal space) |
| wr_off | output | 18 | Register offset |
| wr_bank | output | 1 | Bank select |
| wr_data | output | 32 | Write data |
| trig_valid | output | 1 | Data-less pipe trigger strobe |
| trig_code | output | 8 | Trigger pipe code |

## Verification
Some properties are checked by assertions on every cycle. A stalled bus word holds stable. Every new bus word and every trigger strobe follows an accepted command of the right kind. The violation flag sets after a dropped write and stays set until cleared. Normal-space words carry a zero code. Other behaviour can only be shown by the bench scenarios: exact offset sequences, freezing, wrapping, bank selection, which writes protection removes, and the independence of the two paths. The bench predicts every bus word and trigger, then compares them in order.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  localparam int ADDR_W    = 32;
  localparam int OFF_W     = 18;
  localparam int CODE_W    = 8;
  localparam int NOINC_BIT = 18;
  localparam int BANK_BIT  = 11;

  typedef enum logic [2:0] {
    DST_ADDR  = 3'd0,
    DST_UADDR = 3'd1,
    DST_DATA  = 3'd2,
    DST_DADDR = 3'd3,
    DST_DDATA = 3'd4
  } dest_e;

  typedef struct packed {
    logic              pipe;
    logic [CODE_W-1:0] code;
    logic [OFF_W-1:0]  off;
    logic              bank;
    logic [31:0]       data;
  } wr_item_t;

  // Address after one data write: offset +1 (wrapping) unless frozen
  function automatic logic [ADDR_W-1:0] f_next_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    if (!a[NOINC_BIT]) r[OFF_W-1:0] = a[OFF_W-1:0] + 1'b1;
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] f_code(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: CODE_W];
  endfunction

  function automatic logic f_in_range(input logic [OFF_W-1:0] off,
                                      input logic [OFF_W-1:0] lo,
                                      input logic [OFF_W-1:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction
endpackage

// File: rtl/regwr_prot_table.sv
module regwr_prot_table
  import regwr_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [OFF_W-1:0] lo,
  input  logic [OFF_W-1:0] hi,
  input  logic             en,
  input  logic [OFF_W-1:0] q_off,
  output logic             hit
);
  logic [N-1:0] hit_vec;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [OFF_W-1:0] lo_q, hi_q;
    logic             en_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        en_q <= 1'b0;
      end else if (we && (idx == IDX_W'(i))) begin
        lo_q <= lo;
        hi_q <= hi;
        en_q <= en;
      end
    end
    assign hit_vec[i] = en_q && f_in_range(q_off, lo_q, hi_q);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/regwr_addr_track.sv
module regwr_addr_track
  import regwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_main,
  input  logic              load_chk,
  input  logic [ADDR_W-1:0] value,
  input  logic              adv_main,
  input  logic              load_dir,
  input  logic              adv_dir,
  output logic [ADDR_W-1:0] main_addr,
  output logic              chk_mode,
  output logic [OFF_W-1:0]  dir_off
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_addr <= '0;
      chk_mode  <= 1'b0;
    end else if (load_main) begin
      main_addr <= value;
      chk_mode  <= load_chk;
    end else if (adv_main) begin
      main_addr <= f_next_addr(main_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dir_off <= '0;
    else if (load_dir) dir_off <= value[OFF_W-1:0];
    else if (adv_dir)  dir_off <= dir_off + 1'b1;
  end
endmodule

// File: rtl/regwr_out_stage.sv
module regwr_out_stage
  import regwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  wr_item_t item_in,
  input  logic     ready,
  output logic     valid,
  output wr_item_t item_q,
  output logic     busy
);
  assign busy = valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      item_q <= '0;
    end else if (!busy) begin
      valid <= push;
      if (push) item_q <= item_in;
    end
  end
endmodule

// File: rtl/regwr_port.sv
module regwr_port
  import regwr_pkg::*;
#(
  parameter int          NUM_RANGES = 4,
  parameter logic [7:0]  TRIG_CODE0 = 8'h84,
  parameter logic [7:0]  TRIG_CODE1 = 8'h85,
  localparam int         IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_dest,
  input  logic [31:0]      cmd_value,
  input  logic             prot_we,
  input  logic [IDX_W-1:0] prot_idx,
  input  logic [17:0]      prot_lo,
  input  logic [17:0]      prot_hi,
  input  logic             prot_en,
  input  logic             err_clr,
  output logic             prot_err,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic             wr_pipe,
  output logic [7:0]       wr_code,
  output logic [17:0]      wr_off,
  output logic             wr_bank,
  output logic [31:0]      wr_data,
  output logic             trig_valid,
  output logic [7:0]       trig_code
);
  function automatic logic f_is_trig(input logic [CODE_W-1:0] c);
    return (c == TRIG_CODE0) || (c == TRIG_CODE1);
  endfunction

  logic              busy, acc;
  logic              addr_cmd, chk_cmd, main_wr, dir_wr, daddr_cmd;
  logic [ADDR_W-1:0] main_addr;
  logic              chk_mode, range_hit, main_pipe, viol, push, trig_hit;
  logic [OFF_W-1:0]  dir_off, main_off;
  wr_item_t          item_in, item_q;

  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign chk_cmd   = acc && (cmd_dest == DST_UADDR);
  assign addr_cmd  = acc && ((cmd_dest == DST_ADDR) || (cmd_dest == DST_UADDR));
  assign main_wr   = acc && (cmd_dest == DST_DATA);
  assign daddr_cmd = acc && (cmd_dest == DST_DADDR);
  assign dir_wr    = acc && (cmd_dest == DST_DDATA);

  regwr_addr_track u_addr (
    .clk(clk), .rst_n(rst_n),
    .load_main(addr_cmd), .load_chk(chk_cmd), .value(cmd_value),
    .adv_main(main_wr), .load_dir(daddr_cmd), .adv_dir(dir_wr),
    .main_addr(main_addr), .chk_mode(chk_mode), .dir_off(dir_off)
  );

  assign main_off  = main_addr[OFF_W-1:0];
  assign main_pipe = |f_code(main_addr);

  regwr_prot_table #(.N(NUM_RANGES), .IDX_W(IDX_W)) u_prot (
    .clk(clk), .rst_n(rst_n),
    .we(prot_we), .idx(prot_idx), .lo(prot_lo), .hi(prot_hi), .en(prot_en),
    .q_off(main_off), .hit(range_hit)
  );

  assign viol = main_wr && chk_mode && !main_pipe && range_hit;
  assign push = (main_wr && !viol) || dir_wr;

  always_comb begin
    if (dir_wr) begin
      item_in.pipe = 1'b0;
      item_in.code = '0;
      item_in.off  = dir_off;
      item_in.bank = dir_off[BANK_BIT];
    end else begin
      item_in.pipe = main_pipe;
      item_in.code = f_code(main_addr);
      item_in.off  = main_off;
      item_in.bank = main_off[BANK_BIT];
    end
    item_in.data = cmd_value;
  end

  regwr_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .push(push), .item_in(item_in),
    .ready(wr_ready), .valid(wr_valid), .item_q(item_q), .busy(busy)
  );

  assign wr_pipe = item_q.pipe;
  assign wr_code = item_q.code;
  assign wr_off  = item_q.off;
  assign wr_bank = item_q.bank;
  assign wr_data = item_q.data;

  assign trig_hit = addr_cmd && f_is_trig(f_code(cmd_value));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_valid <= 1'b0;
      trig_code  <= '0;
      prot_err   <= 1'b0;
    end else begin
      trig_valid <= trig_hit;
      if (trig_hit) trig_code <= f_code(cmd_value);
      if (viol)         prot_err <= 1'b1;
      else if (err_clr) prot_err <= 1'b0;
    end
  end
endmodule

// File: rtl/regwr_port_chk.sv
module regwr_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [2:0]  cmd_dest,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_pipe,
  input logic [7:0]  wr_code,
  input logic [17:0] wr_off,
  input logic [31:0] wr_data,
  input logic        trig_valid,
  input logic        prot_err,
  input logic        err_clr,
  input logic        viol
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_off)));

  // R2
  push_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(cmd_valid && cmd_ready && ((cmd_dest == 3'd2) || (cmd_dest == 3'd4))));

  // R5
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> $past(cmd_valid && cmd_ready && (cmd_dest <= 3'd1)));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> prot_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_err && !err_clr) |=> prot_err);

  // R4
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_pipe) |-> (wr_code == 8'h00));
endmodule

bind regwr_port regwr_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_dest(cmd_dest), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_pipe(wr_pipe), .wr_code(wr_code), .wr_off(wr_off), .wr_data(wr_data),
  .trig_valid(trig_valid), .prot_err(prot_err), .err_clr(err_clr), .viol(viol)
);

// File: tb/regwr_port_bench.sv
module regwr_port_bench;
  import regwr_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_dest = '0;
  logic [31:0] cmd_value = '0;
  logic        prot_we = 1'b0, prot_en = 1'b0, err_clr = 1'b0, prot_err;
  logic [1:0]  prot_idx = '0;
  logic [17:0] prot_lo = '0, prot_hi = '0;
  logic        wr_valid, wr_ready = 1'b1, wr_pipe, wr_bank, trig_valid;
  logic [7:0]  wr_code, trig_code;
  logic [17:0] wr_off;
  logic [31:0] wr_data;

  regwr_port u_regwr_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dest(cmd_dest), .cmd_value(cmd_value), .prot_we(prot_we),
    .prot_idx(prot_idx), .prot_lo(prot_lo), .prot_hi(prot_hi), .prot_en(prot_en),
    .err_clr(err_clr), .prot_err(prot_err), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_pipe(wr_pipe), .wr_code(wr_code), .wr_off(wr_off),
    .wr_bank(wr_bank), .wr_data(wr_data), .trig_valid(trig_valid),
    .trig_code(trig_code)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  wr_item_t   exp_q[$];
  logic [7:0] trig_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [2:0] d, input logic [31:0] v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dest = d; cmd_value = v;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic expect_wr(input logic [7:0] code, input logic [17:0] off, input logic [31:0] d);
    wr_item_t it;
    it.pipe = (code != 8'h00); it.code = code; it.off = off; it.bank = off[11]; it.data = d;
    exp_q.push_back(it);
  endtask

  task automatic prog(input logic [1:0] i, input logic [17:0] lo, input logic [17:0] hi, input logic en);
    @(negedge clk);
    prot_we = 1'b1; prot_idx = i; prot_lo = lo; prot_hi = hi; prot_en = en;
    @(negedge clk);
    prot_we = 1'b0;
  endtask

  // Monitor: bus writes (R2 R3 R4 R6 R8 R9 R11)
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected write", {14'h0, wr_off, wr_data}, 64'h0);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        chk(wr_off == e.off,   "R2 offset", 64'(wr_off), 64'(e.off));
        chk(wr_data == e.data, "R2 data", 64'(wr_data), 64'(e.data));
        chk(wr_pipe == e.pipe && wr_code == e.code, "R4 pipe/code", {wr_pipe, wr_code}, {e.pipe, e.code});
        chk(wr_bank == e.bank, "R8 bank", 64'(wr_bank), 64'(e.bank));
      end
    end
    if (rst_n && trig_valid) begin
      if (trig_q.size() == 0) chk(1'b0, "R5 unexpected trigger", 64'(trig_code), 64'h0);
      else begin
        logic [7:0] tc;
        tc = trig_q.pop_front();
        chk(trig_code == tc, "R5 trigger code", 64'(trig_code), 64'(tc));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(wr_valid == 1'b0, "R1 wr_valid", 64'(wr_valid), 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 1);
    chk(prot_err == 1'b0, "R1 prot_err", 64'(prot_err), 0);
    chk(trig_valid == 1'b0, "R1 trig_valid", 64'(trig_valid), 0);
    rst_n = 1'b1;

    // R2 incrementing writes
    send(3'd0, 32'h0000_0100);
    expect_wr(8'h00, 18'h100, 32'hA1); send(3'd2, 32'hA1);
    expect_wr(8'h00, 18'h101, 32'hA2); send(3'd2, 32'hA2);
    expect_wr(8'h00, 18'h102, 32'hA3); send(3'd2, 32'hA3);

    // R3 frozen offset, R8 bank bit set
    send(3'd0, 32'h0004_0A00);
    expect_wr(8'h00, 18'h0A00, 32'hB1); send(3'd2, 32'hB1);
    expect_wr(8'h00, 18'h0A00, 32'hB2); send(3'd2, 32'hB2);

    // R4 pipe space
    send(3'd0, 32'hA000_0000);
    expect_wr(8'hA0, 18'h0, 32'hC1); send(3'd2, 32'hC1);
    expect_wr(8'hA0, 18'h1, 32'hC2); send(3'd2, 32'hC2);

    // R5 data-less triggers
    trig_q.push_back(8'h84); send(3'd0, 32'h8400_0000);
    trig_q.push_back(8'h85); send(3'd1, 32'h8500_0000);
    repeat (2) @(posedge clk); #1;
    chk(trig_q.size() == 0, "R5 trigger seen", 64'(trig_q.size()), 0);
    chk(wr_valid == 1'b0, "R5 no bus write", 64'(wr_valid), 0);

    // R7 checked destination with protected range 0x200..0x20F
    prog(2'd0, 18'h200, 18'h20F, 1'b1);
    send(3'd1, 32'h0000_01FE);
    expect_wr(8'h00, 18'h1FE, 32'hD1); send(3'd2, 32'hD1);
    expect_wr(8'h00, 18'h1FF, 32'hD2); send(3'd2, 32'hD2);
    chk(prot_err == 1'b0, "R7 no error yet", 64'(prot_err), 0);
    send(3'd2, 32'hD3);
    chk(prot_err == 1'b1, "R7 error set", 64'(prot_err), 1);
    send(3'd1, 32'h0000_020F);
    send(3'd2, 32'hD4);
    expect_wr(8'h00, 18'h210, 32'hD5); send(3'd2, 32'hD5);
    repeat (3) @(posedge clk); #1;
    chk(prot_err == 1'b1, "R7 error sticky", 64'(prot_err), 1);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(prot_err == 1'b0, "R7 error cleared", 64'(prot_err), 0);

    // R6 unchecked destination bypasses protection
    send(3'd0, 32'h0000_0205);
    expect_wr(8'h00, 18'h205, 32'hE1); send(3'd2, 32'hE1);
    chk(prot_err == 1'b0, "R6 no error", 64'(prot_err), 0);

    // R9 direct path independent of main address (main now at 0x206)
    send(3'd3, 32'h0000_0300);
    expect_wr(8'h00, 18'h300, 32'hF1); send(3'd4, 32'hF1);
    expect_wr(8'h00, 18'h206, 32'hF2); send(3'd2, 32'hF2);
    expect_wr(8'h00, 18'h301, 32'hF3); send(3'd4, 32'hF3);

    // R12 ignored destination (main at 0x207)
    send(3'd5, 32'h1234_5678);
    send(3'd7, 32'h0000_0000);
    expect_wr(8'h00, 18'h207, 32'h71); send(3'd2, 32'h71);

    // R11 wrap keeps upper bits (pipe code 0x11)
    send(3'd0, 32'h1103_FFFF);
    expect_wr(8'h11, 18'h3FFFF, 32'h81); send(3'd2, 32'h81);
    expect_wr(8'h11, 18'h00000, 32'h82); send(3'd2, 32'h82);

    // R10 stall
    repeat (2) @(posedge clk); #1;
    wr_ready = 1'b0;
    send(3'd0, 32'h0000_0050);
    expect_wr(8'h00, 18'h050, 32'h91); send(3'd2, 32'h91);
    chk(cmd_ready == 1'b0, "R10 cmd_ready low", 64'(cmd_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(wr_valid == 1'b1 && wr_data == 32'h91, "R10 hold", 64'(wr_data), 64'h91);
    end
    @(posedge clk); #1;
    wr_ready = 1'b1;
    expect_wr(8'h00, 18'h051, 32'h92); send(3'd2, 32'h92);

    repeat (4) @(posedge clk); #1;
    chk(exp_q.size() == 0, "R2 all writes seen", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule